// File: doc/BRIEF.md
# Drift-Trimmed Nanosecond Time Base

This block keeps a 64-bit nanosecond time value for precision-time hardware. On every tick of its clock, which has a nominal 16 ns period, the count goes up by 16. Packet capture logic elsewhere on the chip reads the live value from `time_now`. Software controls the block through a small word-wide register port:

- It can stop and restart the count.
- While the count is stopped, it can load a new time one 32-bit half at a time.
- It can read a coherent 64-bit snapshot.

A drift corrector trims the rate of the time base. Software gives it a period in ticks, a step of 0 to 7 ns and a direction. Each time the period runs out, the increment of that one tick becomes 16 plus or minus the step. The period count then starts again. The corrector's configuration may only be changed while its own reset bit is held. Software sets the bit, reads it back, writes the new word, and then clears the bit. Working out the drift settings from a parts-per-billion rate is left to software.

Top module: `ptp_time_gen`

## Requirements
- R1: After reset, `time_now` is 0, the count is running (CTRL register bit 0 reads 1), and the drift configuration and drift reset bit both read 0.
- R2: While running with drift correction idle, `time_now` grows by exactly 16 on every clock cycle, and it carries from the low 32 bits into the high 32 bits.
- R3: Writing 2 to CTRL (address 0) stops the count, and `time_now` then holds its value. Writing 4 restarts it. Writing any other value leaves the run state unchanged.
- R4: While stopped, a write to address 1 replaces bits [31:0] of the time and a write to address 2 replaces bits [63:32]. While running, writes to these addresses are ignored.
- R5: Reading address 3 returns bits [31:0] of the time as it stood in the read's cycle, and saves bits [63:32] of that same value. A later read of address 4 returns the saved half, even if the time has carried since.
- R6: Address 6 bit 0 is the drift reset bit and reads back as written. While it is 1, no correction is applied and the period count is cleared.
- R7: A write to the drift configuration (address 5) takes effect only while the drift reset bit is 1. Otherwise the stored word is unchanged.
- R8: The drift word holds the period in bits [27:0], the step in bits [30:28], and the direction in bit 31 (1 = subtract, 0 = add). Counting from the release of the drift reset, every P-th running tick advances the time by 16 + step or 16 - step, and every other tick advances it by 16.
- R9: A period field of 0, which includes an all-zero word, disables correction whatever the step and direction are.
- R10: Read data is returned with `rd_valid` high in the cycle after `rd_en`.
- R11: The drift period count does not advance while the time base is stopped. It resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| time_now | output | 64 | Current time in nanoseconds |

## Verification
The bench places drift corrections by counting ticks from the release of the drift reset. A corrector whose period count is off by one, or that keeps its count across a reset, would put the 19 ns or 9 ns tick in the wrong place. It stops the time base partway through a drift period to catch a corrector that keeps counting while stopped.

It also tests these cases:
- A snapshot read taken just before a carry into the high half. A design that failed to latch the high half would return the post-carry value.
- A configuration write made while the drift reset is clear. A design that accepted it would change the readback and the tick pattern.
- Load writes and stray control values issued while running. These must not disturb the 16 ns step.

// File: rtl/ptp_tg_pkg.sv
package ptp_tg_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL    = 3'd0,
    A_LOAD_LO = 3'd1,
    A_LOAD_HI = 3'd2,
    A_SNAP_LO = 3'd3,
    A_SNAP_HI = 3'd4,
    A_DCFG    = 3'd5,
    A_DRST    = 3'd6
  } reg_addr_e;

  localparam logic [REG_DW-1:0] CMD_PAUSE  = 32'd2;
  localparam logic [REG_DW-1:0] CMD_RESUME = 32'd4;
endpackage

// File: rtl/ptp_tg_regs.sv
module ptp_tg_regs
  import ptp_tg_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [TIME_W-1:0] time_i,
  input  logic              run_i,
  input  logic [DW-1:0]     dcfg_i,
  input  logic              drst_i,
  output logic              pause_o,
  output logic              resume_o,
  output logic              ld_lo_o,
  output logic              ld_hi_o,
  output logic              dcfg_wr_o,
  output logic              drst_wr_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_valid_o
);
  localparam int HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] snap_hi_q;

  always_comb begin
    pause_o   = wr_en && (wr_addr == A_CTRL) && (wr_data == CMD_PAUSE);
    resume_o  = wr_en && (wr_addr == A_CTRL) && (wr_data == CMD_RESUME);
    ld_lo_o   = wr_en && (wr_addr == A_LOAD_LO);
    ld_hi_o   = wr_en && (wr_addr == A_LOAD_HI);
    dcfg_wr_o = wr_en && (wr_addr == A_DCFG);
    drst_wr_o = wr_en && (wr_addr == A_DRST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      snap_hi_q  <= '0;
    end else begin
      rd_valid_o <= rd_en;
      if (rd_en) begin
        case (rd_addr)
          A_CTRL:    rd_data_o <= DW'(run_i);
          A_SNAP_LO: begin
            rd_data_o <= DW'(time_i[HALF_W-1:0]);
            snap_hi_q <= time_i[TIME_W-1:HALF_W];
          end
          A_SNAP_HI: rd_data_o <= DW'(snap_hi_q);
          A_DCFG:    rd_data_o <= dcfg_i;
          A_DRST:    rd_data_o <= DW'(drst_i);
          default:   rd_data_o <= '0;
        endcase
      end
    end
  end

  // R10: every read strobe produces a valid beat on the next cycle
  a_r10_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid_o);

  // R10: no valid beat without a read strobe
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid_o);
endmodule

// File: rtl/ptp_tg_drift.sv
module ptp_tg_drift #(
  parameter int CFG_W    = 32,
  parameter int PERIOD_W = 28,
  parameter int STEP_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              cfg_wr_i,
  input  logic              rst_wr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              drst_o,
  output logic              adj_en_o,
  output logic              adj_sub_o,
  output logic [STEP_W-1:0] adj_step_o
);
  localparam int STEP_LSB = PERIOD_W;
  localparam int DIR_BIT  = CFG_W - 1;

  logic [CFG_W-1:0]    cfg_q;
  logic                drst_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] period;
  logic                active;
  logic                hit;

  assign period = cfg_q[PERIOD_W-1:0];
  assign active = !drst_q && (period != '0);
  assign hit    = (cnt_q == period - PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      drst_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (rst_wr_i) drst_q <= wdata_i[0];
      if (cfg_wr_i && drst_q) cfg_q <= wdata_i;
      if (!active)       cnt_q <= '0;
      else if (run_i) begin
        if (hit) cnt_q <= '0;
        else     cnt_q <= cnt_q + PERIOD_W'(1);
      end
    end
  end

  assign cfg_o      = cfg_q;
  assign drst_o     = drst_q;
  assign adj_en_o   = active && run_i && hit;
  assign adj_sub_o  = cfg_q[DIR_BIT];
  assign adj_step_o = cfg_q[STEP_LSB +: STEP_W];

  // R6: nothing is applied while the drift reset is held
  a_r6_no_adj_in_reset: assert property (@(posedge clk) disable iff (rst)
    drst_q |-> !adj_en_o);

  // R7: the configuration word is frozen whenever the drift reset is clear
  a_r7_cfg_guard: assert property (@(posedge clk) disable iff (rst)
    !drst_q |=> $stable(cfg_q));

  // R11: the period count holds while the time base is stopped
  a_r11_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !drst_q && !cfg_wr_i) |=> $stable(cnt_q));

  // R8: after an applied correction the period count restarts
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    adj_en_o |=> (cnt_q == '0));
endmodule

// File: rtl/ptp_tg_counter.sv
module ptp_tg_counter #(
  parameter int TIME_W  = 64,
  parameter int DW      = 32,
  parameter int NOM_INC = 16,
  parameter int STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pause_i,
  input  logic              resume_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              adj_en_i,
  input  logic              adj_sub_i,
  input  logic [STEP_W-1:0] adj_step_i,
  output logic [TIME_W-1:0] time_o,
  output logic              run_o
);
  localparam int HALF_W = TIME_W / 2;
  localparam int MAX_STEP = (1 << STEP_W) - 1;

  logic [TIME_W-1:0] time_q;
  logic              run_q;
  logic [TIME_W-1:0] inc;

  always_comb begin
    inc = TIME_W'(NOM_INC);
    if (adj_en_i) begin
      if (adj_sub_i) inc = TIME_W'(NOM_INC) - TIME_W'(adj_step_i);
      else           inc = TIME_W'(NOM_INC) + TIME_W'(adj_step_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b1;
      time_q <= '0;
    end else begin
      if (pause_i)       run_q <= 1'b0;
      else if (resume_i) run_q <= 1'b1;
      if (run_q) time_q <= time_q + inc;
      else begin
        if (ld_lo_i) time_q[HALF_W-1:0]      <= wdata_i[HALF_W-1:0];
        if (ld_hi_i) time_q[TIME_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
      end
    end
  end

  assign time_o = time_q;
  assign run_o  = run_q;

  // R3: a stopped time base without load writes holds its value
  a_r3_hold_paused: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ld_lo_i && !ld_hi_i) |=> $stable(time_q));

  // R2/R8: a running tick advances by the nominal amount within the step range
  a_r8_inc_range: assert property (@(posedge clk) disable iff (rst)
    run_q |=> ((time_q - $past(time_q)) >= TIME_W'(NOM_INC - MAX_STEP) &&
               (time_q - $past(time_q)) <= TIME_W'(NOM_INC + MAX_STEP)));
endmodule

// File: rtl/ptp_time_gen.sv
module ptp_time_gen
  import ptp_tg_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int DW       = 32,
  parameter int NOM_INC  = 16,
  parameter int PERIOD_W = 28,
  parameter int STEP_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic [63:0]       time_now
);
  logic              pause, resume, ld_lo, ld_hi, dcfg_wr, drst_wr;
  logic              run;
  logic [DW-1:0]     dcfg;
  logic              drst;
  logic              adj_en, adj_sub;
  logic [STEP_W-1:0] adj_step;
  logic [TIME_W-1:0] time_q;

  ptp_tg_regs #(.TIME_W(TIME_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .time_i(time_q), .run_i(run), .dcfg_i(dcfg), .drst_i(drst),
    .pause_o(pause), .resume_o(resume), .ld_lo_o(ld_lo), .ld_hi_o(ld_hi),
    .dcfg_wr_o(dcfg_wr), .drst_wr_o(drst_wr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  ptp_tg_drift #(.CFG_W(DW), .PERIOD_W(PERIOD_W), .STEP_W(STEP_W)) u_drift (
    .clk(clk), .rst(rst), .run_i(run),
    .cfg_wr_i(dcfg_wr), .rst_wr_i(drst_wr), .wdata_i(wr_data),
    .cfg_o(dcfg), .drst_o(drst),
    .adj_en_o(adj_en), .adj_sub_o(adj_sub), .adj_step_o(adj_step)
  );

  ptp_tg_counter #(.TIME_W(TIME_W), .DW(DW), .NOM_INC(NOM_INC), .STEP_W(STEP_W)) u_cnt (
    .clk(clk), .rst(rst),
    .pause_i(pause), .resume_i(resume), .ld_lo_i(ld_lo), .ld_hi_i(ld_hi),
    .wdata_i(wr_data),
    .adj_en_i(adj_en), .adj_sub_i(adj_sub), .adj_step_i(adj_step),
    .time_o(time_q), .run_o(run)
  );

  assign time_now = time_q;

  // R4: loads never land while running
  a_r4_no_load_running: assert property (@(posedge clk) disable iff (rst)
    (run && !adj_en) |=> (time_q == $past(time_q) + TIME_W'(NOM_INC)));
endmodule

// File: tb/ptp_time_gen_bench.sv
`timescale 1ns/1ps
module ptp_time_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [63:0] time_now;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] snap_hi_exp;

  always #2.5 clk = ~clk;

  ptp_time_gen u_ptp_time_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .time_now(time_now)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] expv, string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_snap_lo();
    logic [63:0] t;
    t = time_now;
    snap_hi_exp = t[63:32];
    rd(3'd3, t[31:0], "R5 snapshot low");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected read beat", 64'(rd_data), 64'd0);
      else begin
        logic [31:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(rd_data == e, tg, 64'(rd_data), 64'(e));
      end
    end
  end

  task automatic tick_check(int n, int start, int per, int step, bit sub, string tag);
    logic [63:0] prev, cur, d, e;
    prev = time_now;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      cur = time_now;
      d = cur - prev;
      if (per != 0 && ((start + k) % per) == 0)
        e = sub ? 64'(16 - step) : 64'(16 + step);
      else
        e = 64'd16;
      check(d == e, tag, d, e);
      prev = cur;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(time_now == 64'd0, "R1 time after reset", time_now, 64'd0);
    tick_check(6, 0, 0, 0, 0, "R2 nominal step");
    rd(3'd0, 32'd1, "R1 running after reset");
    rd(3'd5, 32'd0, "R1 drift cfg after reset");
    rd(3'd6, 32'd0, "R1 drift reset after reset");

    // R8: add step 3 every 4th tick
    wr(3'd6, 32'd1);
    rd(3'd6, 32'd1, "R6 drift reset readback");
    wr(3'd5, 32'h3000_0004);
    rd(3'd5, 32'h3000_0004, "R7 cfg accepted in reset");
    tick_check(3, 0, 0, 0, 0, "R6 no correction while reset held");
    wr(3'd6, 32'd0);
    tick_check(12, 0, 4, 3, 0, "R8 add every 4th tick");

    // R8: subtract step 7 every tick; counter restarts after reset
    wr(3'd6, 32'd1);
    wr(3'd5, 32'hF000_0001);
    wr(3'd6, 32'd0);
    tick_check(5, 0, 1, 7, 1, "R8 subtract every tick");

    // R7: write while drift reset clear is ignored
    wr(3'd5, 32'h3000_0002);
    rd(3'd5, 32'hF000_0001, "R7 cfg ignored outside reset");
    tick_check(3, 0, 1, 7, 1, "R7 behaviour unchanged");

    // R11: pause mid-period
    wr(3'd6, 32'd1);
    wr(3'd5, 32'h2000_0003);
    wr(3'd6, 32'd0);
    tick_check(1, 0, 3, 2, 0, "R11 before pause");
    wr(3'd0, 32'd2);
    t = time_now;
    repeat (5) @(negedge clk);
    check(time_now == t, "R3 held while paused", time_now, t);
    rd(3'd0, 32'd0, "R3 run bit clear");
    wr(3'd0, 32'd4);
    tick_check(4, 2, 3, 2, 0, "R11 period resumes");

    // R9: period zero disables correction
    wr(3'd6, 32'd1);
    wr(3'd5, 32'h7000_0000);
    wr(3'd6, 32'd0);
    tick_check(6, 0, 0, 0, 0, "R9 zero period with step");
    wr(3'd6, 32'd1);
    wr(3'd5, 32'h0);
    wr(3'd6, 32'd0);
    tick_check(4, 0, 0, 0, 0, "R9 all-zero word");

    // R3: other control values ignored
    t = time_now;
    wr(3'd0, 32'd3);
    check(time_now == t + 64'd16, "R3 stray control value", time_now, t + 64'd16);
    // R4: load while running ignored
    t = time_now;
    wr(3'd1, 32'h1234_5678);
    check(time_now == t + 64'd16, "R4 load ignored while running", time_now, t + 64'd16);

    // R4: load while paused, then carry
    wr(3'd0, 32'd2);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'h0000_0001);
    check(time_now == 64'h1_FFFF_FFF0, "R4 loaded value", time_now, 64'h1_FFFF_FFF0);
    wr(3'd0, 32'd4);
    @(negedge clk);
    check(time_now == 64'h2_0000_0000, "R2 carry into high half", time_now, 64'h2_0000_0000);

    // R5: snapshot across a carry
    wr(3'd0, 32'd2);
    wr(3'd1, 32'hFFFF_FFE0);
    wr(3'd2, 32'h0000_0005);
    wr(3'd0, 32'd4);
    rd_snap_lo();
    rd(3'd4, snap_hi_exp, "R5 snapshot high held");
    check(time_now[63:32] == 32'd6, "R5 live time carried", 64'(time_now[63:32]), 64'd6);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads returned", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule